// File: doc/BRIEF.md
# Power-Cycle Output Level Sequencer

This block lives in a small always-clocked domain that keeps running while the main supply is briefly gone. It watches a single main-power-present input. Each time power comes back, it looks at how long power was absent. A short absence counts as a deliberate quick toggle of the wall switch, and the block moves the light output to the next step of a brightness sequence. A long absence counts as an ordinary switch-on, and the sequence restarts at full output.

Two strap inputs choose the sequence. The straps are captured only at the moment power returns. The result is a 2-bit level code that the downstream current-threshold logic uses as a scale factor. The code is qualified by a valid flag that is high only while power is present. The length of the short-absence window is a parameter counted in clock cycles.

Top module: `pwr_level_seq`

## Requirements
- R1: While `rst_n` is low, `level_valid` is 0 and `level_code` is 00. The first power-on after reset starts at full output (code 00).
- R2: `level_valid` equals the value `pwr_ok` had at the previous clock edge. `level_code` reads 00 whenever `level_valid` is 0.
- R3: A power-on that follows fewer than `HOLD_CYCLES` low samples of `pwr_ok` advances the level one step in the selected sequence. The new code appears at the same edge that raises `level_valid`.
- R4: A power-on that follows `HOLD_CYCLES` or more low samples of `pwr_ok` restarts at code 00.
- R5: With both straps low (`strap_a_gnd`=0, `strap_b_gnd`=0), the code is always 00.
- R6: With `strap_b_gnd`=1 and `strap_a_gnd`=0, quick toggles step through codes 00 (100%) → 10 (30%) → 00, and repeat.
- R7: With `strap_a_gnd`=1 and `strap_b_gnd`=0, quick toggles step through codes 00 (100%) → 01 (50%) → 00, and repeat.
- R8: With both straps at 1, quick toggles step through codes 00 (100%) → 01 (50%) → 11 (20%) → 00, and repeat.
- R9: If the strap pair captured at a power-on differs from the pair captured at the previous power-on, the level is 00, even after a quick toggle.
- R10: Strap changes while power stays present have no effect on `level_code`. While `level_valid` stays high, the code does not change.
- R11: The quick/normal boundary is exact. `HOLD_CYCLES`-1 low samples count as quick, and `HOLD_CYCLES` low samples count as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock of the retained domain |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| pwr_ok | input | 1 | Main power present (1 = on) |
| strap_a_gnd | input | 1 | First sequence strap, 1 = tied to ground |
| strap_b_gnd | input | 1 | Second sequence strap, 1 = tied to ground |
| level_code | output | 2 | 00 = 100%, 01 = 50%, 10 = 30%, 11 = 20% |
| level_valid | output | 1 | Level code is meaningful (power present) |

## Verification
Every result of this block appears one clock edge after the power-on that causes it. The edge that first samples `pwr_ok` high also updates the off-time verdict, the captured straps and the level index, so both `level_valid` and `level_code` are due right after that single edge. The bench changes inputs one time unit after a rising edge and samples one time unit after the following edge. It counts exactly N edges with `pwr_ok` low to produce an off interval of N samples. This is how the boundary cases at `HOLD_CYCLES`-1 and `HOLD_CYCLES` are set up, and each expected code comes from the strap sequence tables in the requirements.

// File: rtl/pls_pkg.sv
package pls_pkg;

    typedef enum logic [1:0] {
        LVL_FULL = 2'b00,
        LVL_HALF = 2'b01,
        LVL_P30  = 2'b10,
        LVL_P20  = 2'b11
    } level_e;

    typedef struct packed {
        logic a_gnd;
        logic b_gnd;
    } strap_t;

    localparam int MAX_STEPS = 3;
    localparam int IDX_W     = $clog2(MAX_STEPS);

endpackage

// File: rtl/pls_off_timer.sv
module pls_off_timer #(
    parameter int HOLD_CYCLES = 40_000_000,
    parameter int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    output logic             quick,
    output logic [CNT_W-1:0] off_cnt
);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_ok) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < HOLD_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    // A cold start loads the saturated value, so the first power-up counts as normal.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= HOLD_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign off_cnt = st_q.cnt;
    assign quick   = (st_q.cnt < HOLD_V);

    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        off_cnt <= HOLD_V);

    assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok && off_cnt == HOLD_V) |=> (off_cnt == HOLD_V));

endmodule

// File: rtl/pls_seq_table.sv
module pls_seq_table
    import pls_pkg::*;
(
    input  strap_t           strap,
    input  logic [IDX_W-1:0] idx,
    output level_e           level,
    output logic [IDX_W-1:0] seq_len
);
    always_comb begin
        level   = LVL_FULL;
        seq_len = IDX_W'(1);
        unique case ({strap.a_gnd, strap.b_gnd})
            2'b00: begin
                seq_len = IDX_W'(1);
                level   = LVL_FULL;
            end
            2'b01: begin
                seq_len = IDX_W'(2);
                level   = (idx == IDX_W'(1)) ? LVL_P30 : LVL_FULL;
            end
            2'b10: begin
                seq_len = IDX_W'(2);
                level   = (idx == IDX_W'(1)) ? LVL_HALF : LVL_FULL;
            end
            default: begin
                seq_len = IDX_W'(3);
                case (idx)
                    IDX_W'(1): level = LVL_HALF;
                    IDX_W'(2): level = LVL_P20;
                    default:   level = LVL_FULL;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/pls_step_index.sv
module pls_step_index
    import pls_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_rise,
    input  logic             quick,
    input  strap_t           strap_in,
    input  logic [IDX_W-1:0] seq_len,
    output logic [IDX_W-1:0] idx,
    output strap_t           strap_held
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        strap_t           strap;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic       strap_moved;
    logic [IDX_W-1:0] idx_inc;

    always_comb begin
        st_d        = st_q;
        strap_moved = (strap_in != st_q.strap);
        idx_inc     = st_q.idx + 1'b1;
        if (power_rise) begin
            st_d.strap = strap_in;
            if (strap_moved || !quick) begin
                st_d.idx = '0;
            end else if (idx_inc >= seq_len) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = idx_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.strap <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx        = st_q.idx;
    assign strap_held = st_q.strap;

    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx < seq_len);

    assert_long_off_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (power_rise && !quick) |=> (idx == '0));

    assert_no_steps_floating_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_held == strap_t'(2'b00)) |-> (idx == '0));

endmodule

// File: rtl/pwr_level_seq.sv
module pwr_level_seq
    import pls_pkg::*;
#(
    parameter int HOLD_CYCLES = 40_000_000,
    parameter int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       strap_a_gnd,
    input  logic       strap_b_gnd,
    output logic [1:0] level_code,
    output logic       level_valid
);
    typedef struct packed {
        logic pwr;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             power_rise;
    logic             quick;
    logic [CNT_W-1:0] off_cnt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] seq_len;
    strap_t           strap_in;
    strap_t           strap_held;
    level_e           level;

    assign strap_in   = '{a_gnd: strap_a_gnd, b_gnd: strap_b_gnd};
    assign power_rise = pwr_ok && !st_q.pwr;

    always_comb begin
        st_d     = st_q;
        st_d.pwr = pwr_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pwr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pls_off_timer #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_ok  (pwr_ok),
        .quick   (quick),
        .off_cnt (off_cnt)
    );

    pls_step_index u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_rise (power_rise),
        .quick      (quick),
        .strap_in   (strap_in),
        .seq_len    (seq_len),
        .idx        (idx),
        .strap_held (strap_held)
    );

    pls_seq_table u_table (
        .strap   (strap_held),
        .idx     (idx),
        .level   (level),
        .seq_len (seq_len)
    );

    assign level_valid = st_q.pwr;
    assign level_code  = level_valid ? level : LVL_FULL;

    assert_timer_clear_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level_valid |-> (off_cnt == '0));

    assert_stable_while_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (level_valid && $past(level_valid)) |-> $stable(level_code));

    assert_strap_change_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (power_rise && (strap_in != strap_held)) |=> (level_code == LVL_FULL));

endmodule

// File: tb/pwr_level_seq_test.sv
module pwr_level_seq_test;
    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       strap_a_gnd = 1'b0;
    logic       strap_b_gnd = 1'b0;
    logic [1:0] level_code;
    logic       level_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwr_level_seq #(.HOLD_CYCLES(HOLD)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok      (pwr_ok),
        .strap_a_gnd (strap_a_gnd),
        .strap_b_gnd (strap_b_gnd),
        .level_code  (level_code),
        .level_valid (level_valid)
    );

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic edge_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Power off for exactly n sampled edges, then power on and sample after one edge.
    task automatic toggle(input int n);
        pwr_ok = 1'b0;
        edge_n(n);
        pwr_ok = 1'b1;
        edge_n(1);
    endtask

    task automatic set_strap(input logic a, input logic b);
        strap_a_gnd = a;
        strap_b_gnd = b;
    endtask

    task automatic t_reset;
        edge_n(2);
        check("R1 valid in reset", {1'b0, level_valid}, 2'b00);
        check("R1 code in reset", level_code, 2'b00);
        rst_n = 1'b1;
        edge_n(1);
    endtask

    task automatic t_floating;
        set_strap(1'b0, 1'b0);
        pwr_ok = 1'b1;
        edge_n(1);
        check("R2 valid after power-on", {1'b0, level_valid}, 2'b01);
        check("R1 first power-on full", level_code, 2'b00);
        pwr_ok = 1'b0;
        edge_n(1);
        check("R2 valid drops", {1'b0, level_valid}, 2'b00);
        check("R2 code zero while off", level_code, 2'b00);
        edge_n(2);
        pwr_ok = 1'b1;
        edge_n(1);
        check("R5 floating quick 1", level_code, 2'b00);
        toggle(4);
        check("R5 floating quick 2", level_code, 2'b00);
    endtask

    task automatic t_b_only;
        set_strap(1'b0, 1'b1);
        toggle(HOLD + 4);
        check("R6 start", level_code, 2'b00);
        toggle(3);
        check("R6 step 30", level_code, 2'b10);
        toggle(3);
        check("R6 wrap full", level_code, 2'b00);
        toggle(3);
        check("R6 repeat 30", level_code, 2'b10);
    endtask

    task automatic t_a_only;
        set_strap(1'b1, 1'b0);
        toggle(HOLD + 4);
        check("R7 start", level_code, 2'b00);
        toggle(5);
        check("R7 step 50", level_code, 2'b01);
        toggle(5);
        check("R7 wrap full", level_code, 2'b00);
    endtask

    task automatic t_both;
        set_strap(1'b1, 1'b1);
        toggle(HOLD + 4);
        check("R8 start", level_code, 2'b00);
        toggle(2);
        check("R8 step 50", level_code, 2'b01);
        toggle(2);
        check("R8 step 20", level_code, 2'b11);
        toggle(2);
        check("R8 wrap full", level_code, 2'b00);
    endtask

    task automatic t_boundary;
        set_strap(1'b1, 1'b1);
        toggle(1);
        check("R3 quick advance", level_code, 2'b01);
        toggle(HOLD);
        check("R4 R11 window reached restarts", level_code, 2'b00);
        toggle(HOLD - 1);
        check("R11 one below window advances", level_code, 2'b01);
        toggle(HOLD + 40);
        check("R4 long off restarts", level_code, 2'b00);
    endtask

    task automatic t_strap_change;
        set_strap(1'b1, 1'b1);
        toggle(HOLD + 2);
        toggle(2);
        check("R9 setup at 50", level_code, 2'b01);
        pwr_ok = 1'b0;
        edge_n(1);
        set_strap(1'b1, 1'b0);
        edge_n(1);
        pwr_ok = 1'b1;
        edge_n(1);
        check("R9 new strap restarts", level_code, 2'b00);
        toggle(2);
        check("R9 new sequence steps", level_code, 2'b01);
    endtask

    task automatic t_strap_while_on;
        set_strap(1'b1, 1'b1);
        toggle(HOLD + 2);
        toggle(2);
        check("R10 setup at 50", level_code, 2'b01);
        set_strap(1'b0, 1'b1);
        edge_n(3);
        check("R10 strap ignored while on", level_code, 2'b01);
        set_strap(1'b0, 1'b0);
        edge_n(3);
        check("R10 strap ignored again", level_code, 2'b01);
        set_strap(1'b1, 1'b1);
        toggle(2);
        check("R10 sequence intact", level_code, 2'b11);
    endtask

    initial begin
        fork
            begin
                #1;
                t_reset();
                t_floating();
                t_b_only();
                t_a_only();
                t_both();
                t_boundary();
                t_strap_change();
                t_strap_while_on();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule